// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the state update a processor core needs when it takes a trap. The core presents the PC of the instruction being interrupted, together with up to four kinds of entry request in the same cycle: a synchronous exception (with a cause code and an optional faulting virtual address), a debug request with its own cause, an interrupt already accepted by the interrupt controller together with its level, and a non-maskable interrupt. The unit selects one request and updates the status word, the per-level saved PC and saved status registers, the double-fault PC register, the cause register, the debug cause register and the fault address register. It then produces a one-cycle redirect pulse carrying the 32-bit handler address.

Ordinary faults go to one of three handlers: user, kernel or double fault. The choice depends on the user-mode and exception-mode bits of the status word. A level-1 interrupt does not get its own handler. It goes through the same fault path with a fixed cause code. Interrupts above level 1, debug events and the non-maskable interrupt each save state into the register pair of their own level. Every handler address is an offset applied to a run-time vector base register.

The status word is 8 bits wide. Bits [3:0] hold the interrupt level, bit 4 is the exception-mode bit and bit 5 is the user-mode bit. The core can load the status word and the vector base through dedicated write ports, for example on a return from a handler. With the default parameters there are 6 interrupt levels, debug runs at level 6, the non-maskable interrupt runs at level 7 and the exception-mode masking level is 3.

Top module: `exc_entry`

## Requirements
- R1: A synchronous exception taken while status bit 4 is 0 stores the PC in the level-1 saved PC and stores the cause in the cause register. It sets status bit 4 and redirects to base+0x340 when status bit 5 is 1, or to base+0x300 when status bit 5 is 0.
- R2: A synchronous exception taken while status bit 4 is 1 is a double fault. It stores the PC in the double-fault PC register, leaves the level-1 saved PC unchanged and redirects to base+0x3C0.
- R3: The fault address register loads the exception's virtual address only when the exception is taken with its address-valid flag set. Every other entry leaves the register unchanged.
- R4: A debug request stores its cause in the debug cause register, the PC in the level-6 saved PC and the old status word in the level-6 saved status. It sets status[3:0] to 6 and sets bit 4, keeps bit 5, and redirects to base+0x020.
- R5: A debug request is ignored when the current interrupt level is 6 or more. In that case there is no redirect and no state changes.
- R6: An interrupt at level L, with 2 <= L <= 6 and L greater than the current interrupt level, stores the PC and the status word in the level-L pair. It sets status[3:0] to L and sets bit 4, then redirects to base+0x180+0x40*(L-2). An interrupt at level 0, at a level above 6, or at a level not above the current interrupt level is ignored.
- R7: A taken level-1 interrupt writes cause code 4 into the cause register and then follows the R1 or R2 path. The fault address register is not changed.
- R8: A non-maskable interrupt is always taken, at level 7, whatever the status word holds. It stores the PC and status in the level-7 pair, sets status[3:0] to 7 and bit 4, and redirects to base+0x2C0.
- R9: The handler address is the value of the vector base register plus the handler offset. The vector base register resets to 0x4000_0000 and can be rewritten.
- R10: The current interrupt level is the larger of status[3:0] and 3 while bit 4 is set, and equals status[3:0] otherwise.
- R11: When several requests are eligible in one cycle, only one is taken, in the order: non-maskable, debug, interrupt, exception. The losing requests change no state.
- R12: The redirect output is registered. It pulses for exactly the one cycle that follows the request edge, and it stays low when no request is taken.
- R13: A taken entry overrides a status load in the same cycle. When no entry is taken, the status load writes status directly.
- R14: Reset clears the status word, the saved registers, the causes, the fault address and the redirect output, and loads the vector base with 0x4000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC to save on entry |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 6 | Exception cause code |
| exc_vaddr_vld_i | input | 1 | Exception carries a faulting address |
| exc_vaddr_i | input | 32 | Faulting virtual address |
| dbg_req_i | input | 1 | Debug event request |
| dbg_cause_i | input | 6 | Debug cause code |
| irq_req_i | input | 1 | Accepted interrupt request |
| irq_level_i | input | 4 | Level of the accepted interrupt |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| ps_we_i | input | 1 | Status word load strobe |
| ps_wdata_i | input | 8 | Status word load value |
| vecbase_we_i | input | 1 | Vector base load strobe |
| vecbase_wdata_i | input | 32 | Vector base load value |
| lvl_sel_i | input | 4 | Level selecting the saved PC and saved status readout |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Handler address |
| ps_o | output | 8 | Status word |
| cause_o | output | 6 | Cause register |
| dbg_cause_o | output | 6 | Debug cause register |
| fault_addr_o | output | 32 | Fault address register |
| depc_o | output | 32 | Double-fault PC register |
| epc_sel_o | output | 32 | Saved PC of level lvl_sel_i (0 when out of range) |
| eps_sel_o | output | 8 | Saved status of level lvl_sel_i (0 below level 2) |

## Verification
The bench targets the boundaries of the current-level comparison. It sends level-3 and level-4 interrupts while only the exception-mode bit is set. A design that ignores the masking level would take the level-3 interrupt, and one that compares with >= would take or drop the wrong one. It also sends a debug request at interrupt level 6, and an interrupt at level 7 through the ordinary interrupt port. Both must be dropped.

The bench raises double faults to confirm that the double-fault PC is written and the level-1 saved PC is not. A design that mixed these up would overwrite the return address of the first fault. Level-1 interrupts are checked for cause code 4 and for an unchanged fault address. Stacked simultaneous requests check that the losing requests leave the cause registers alone. A rewritten vector base must move every handler.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_W        = 8;
  localparam int LVL_W       = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;

  typedef enum logic [2:0] {
    ENT_NONE,
    ENT_NMI,
    ENT_DBG,
    ENT_HIGH,
    ENT_GEN
  } ent_kind_e;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int NLEVEL      = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter int NMI_LEVEL   = 7
) (
  input  logic [LVL_W-1:0] cint_i,
  input  logic             nmi_req_i,
  input  logic             dbg_req_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic             exc_req_i,
  output ent_kind_e        kind_o,
  output logic [LVL_W-1:0] level_o,
  output logic             gen_irq_o
);
  logic dbg_ok, irq_ok;

  assign dbg_ok = dbg_req_i && (cint_i < LVL_W'(DEBUG_LEVEL));
  assign irq_ok = irq_req_i && (irq_level_i > cint_i) &&
                  (irq_level_i <= LVL_W'(NLEVEL));

  always_comb begin
    kind_o    = ENT_NONE;
    level_o   = '0;
    gen_irq_o = 1'b0;
    if (nmi_req_i) begin
      kind_o  = ENT_NMI;
      level_o = LVL_W'(NMI_LEVEL);
    end else if (dbg_ok) begin
      kind_o  = ENT_DBG;
      level_o = LVL_W'(DEBUG_LEVEL);
    end else if (irq_ok) begin
      if (irq_level_i == LVL_W'(1)) begin
        kind_o    = ENT_GEN;
        level_o   = LVL_W'(1);
        gen_irq_o = 1'b1;
      end else begin
        kind_o  = ENT_HIGH;
        level_o = irq_level_i;
      end
    end else if (exc_req_i) begin
      kind_o  = ENT_GEN;
      level_o = LVL_W'(1);
    end
  end
endmodule

// File: rtl/exc_entry_reloc.sv
module exc_entry_reloc #(
  parameter bit          RELOC_EN        = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000
) (
  input  logic [31:0] off_i,
  input  logic [31:0] vecbase_i,
  output logic [31:0] target_o
);
  // configured vector = default base + offset; relocated = that - default + run-time base
  if (RELOC_EN) begin : g_reloc
    assign target_o = vecbase_i + off_i;
  end else begin : g_fixed
    logic unused_base;
    assign unused_base = ^vecbase_i;
    assign target_o    = DEFAULT_VECBASE + off_i;
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int          NLEVEL          = 6,
  parameter int          DEBUG_LEVEL     = 6,
  parameter int          NMI_LEVEL       = 7,
  parameter int          EXCM_LEVEL      = 3,
  parameter int          CAUSE_W         = 6,
  parameter int          L1_IRQ_CAUSE    = 4,
  parameter bit          HAS_DEPC        = 1'b1,
  parameter bit          RELOC_EN        = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000,
  parameter logic [31:0] KRN_VEC_OFF     = 32'h300,
  parameter logic [31:0] USR_VEC_OFF     = 32'h340,
  parameter logic [31:0] DBL_VEC_OFF     = 32'h3C0,
  parameter logic [31:0] DBG_VEC_OFF     = 32'h020,
  parameter logic [31:0] INT_VEC_OFF     = 32'h180,
  parameter int          INT_VEC_SHIFT   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        pc_i,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               exc_vaddr_vld_i,
  input  logic [31:0]        exc_vaddr_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic               irq_req_i,
  input  logic [LVL_W-1:0]   irq_level_i,
  input  logic               nmi_req_i,
  input  logic               ps_we_i,
  input  logic [PS_W-1:0]    ps_wdata_i,
  input  logic               vecbase_we_i,
  input  logic [31:0]        vecbase_wdata_i,
  input  logic [LVL_W-1:0]   lvl_sel_i,
  output logic               redirect_valid_o,
  output logic [31:0]        redirect_pc_o,
  output logic [PS_W-1:0]    ps_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [CAUSE_W-1:0] dbg_cause_o,
  output logic [31:0]        fault_addr_o,
  output logic [31:0]        depc_o,
  output logic [31:0]        epc_sel_o,
  output logic [PS_W-1:0]    eps_sel_o
);
  localparam int NEPC = NMI_LEVEL;
  localparam int NEPS = NMI_LEVEL - 1;

  logic [PS_W-1:0]    ps_q, ps_nxt;
  logic [CAUSE_W-1:0] cause_q, dbg_cause_q;
  logic [31:0]        fault_q, vecbase_q, depc_q, redir_pc_q;
  logic               redir_vld_q;
  logic [31:0]        epc_q [NEPC];
  logic [PS_W-1:0]    eps_q [NEPS];

  logic [LVL_W-1:0]   il, cint, ent_level;
  logic               excm, um, gen_irq, take, dbl;
  ent_kind_e          ent_kind;
  logic [31:0]        vec_off, vec_tgt;

  assign il   = ps_q[LVL_W-1:0];
  assign excm = ps_q[PS_EXCM_BIT];
  assign um   = ps_q[PS_UM_BIT];
  assign cint = (excm && il < LVL_W'(EXCM_LEVEL)) ? LVL_W'(EXCM_LEVEL) : il;

  exc_entry_arb #(
    .NLEVEL     (NLEVEL),
    .DEBUG_LEVEL(DEBUG_LEVEL),
    .NMI_LEVEL  (NMI_LEVEL)
  ) u_arb (
    .cint_i     (cint),
    .nmi_req_i  (nmi_req_i),
    .dbg_req_i  (dbg_req_i),
    .irq_req_i  (irq_req_i),
    .irq_level_i(irq_level_i),
    .exc_req_i  (exc_req_i),
    .kind_o     (ent_kind),
    .level_o    (ent_level),
    .gen_irq_o  (gen_irq)
  );

  assign take = (ent_kind != ENT_NONE);
  assign dbl  = (ent_kind == ENT_GEN) && excm;

  always_comb begin
    unique case (ent_kind)
      ENT_GEN:  vec_off = dbl ? DBL_VEC_OFF : (um ? USR_VEC_OFF : KRN_VEC_OFF);
      ENT_DBG:  vec_off = DBG_VEC_OFF;
      ENT_NMI,
      ENT_HIGH: vec_off = INT_VEC_OFF +
                          ({{(32-LVL_W){1'b0}}, ent_level - LVL_W'(2)} << INT_VEC_SHIFT);
      default:  vec_off = '0;
    endcase
  end

  exc_entry_reloc #(
    .RELOC_EN       (RELOC_EN),
    .DEFAULT_VECBASE(DEFAULT_VECBASE)
  ) u_reloc (
    .off_i    (vec_off),
    .vecbase_i(vecbase_q),
    .target_o (vec_tgt)
  );

  always_comb begin
    ps_nxt = ps_q;
    ps_nxt[PS_EXCM_BIT] = 1'b1;
    if (ent_kind != ENT_GEN) ps_nxt[LVL_W-1:0] = ent_level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q        <= '0;
      cause_q     <= '0;
      dbg_cause_q <= '0;
      fault_q     <= '0;
      vecbase_q   <= DEFAULT_VECBASE;
      redir_vld_q <= 1'b0;
      redir_pc_q  <= '0;
      for (int l = 0; l < NEPC; l++) epc_q[l] <= '0;
      for (int l = 0; l < NEPS; l++) eps_q[l] <= '0;
    end else begin
      redir_vld_q <= take;
      if (take) redir_pc_q <= vec_tgt;
      if (vecbase_we_i) vecbase_q <= vecbase_wdata_i;
      if (take)         ps_q <= ps_nxt;
      else if (ps_we_i) ps_q <= ps_wdata_i;
      if (ent_kind == ENT_GEN)
        cause_q <= gen_irq ? CAUSE_W'(L1_IRQ_CAUSE) : exc_cause_i;
      if (ent_kind == ENT_DBG) dbg_cause_q <= dbg_cause_i;
      if (ent_kind == ENT_GEN && !gen_irq && exc_vaddr_vld_i) fault_q <= exc_vaddr_i;
      // level-1 saved PC: ordinary faults, or double faults without a dedicated register
      if (ent_kind == ENT_GEN && (!dbl || !HAS_DEPC)) epc_q[0] <= pc_i;
      for (int l = 2; l <= NMI_LEVEL; l++) begin
        if ((ent_kind == ENT_NMI || ent_kind == ENT_DBG || ent_kind == ENT_HIGH) &&
            ent_level == LVL_W'(l)) begin
          epc_q[l-1] <= pc_i;
          eps_q[l-2] <= ps_q;
        end
      end
    end
  end

  if (HAS_DEPC) begin : g_depc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  depc_q <= '0;
      else if (dbl) depc_q <= pc_i;
    end
  end else begin : g_no_depc
    assign depc_q = '0;
  end

  always_comb begin
    epc_sel_o = '0;
    eps_sel_o = '0;
    for (int l = 1; l <= NMI_LEVEL; l++)
      if (lvl_sel_i == LVL_W'(l)) epc_sel_o = epc_q[l-1];
    for (int l = 2; l <= NMI_LEVEL; l++)
      if (lvl_sel_i == LVL_W'(l)) eps_sel_o = eps_q[l-2];
  end

  assign redirect_valid_o = redir_vld_q;
  assign redirect_pc_o    = redir_pc_q;
  assign ps_o             = ps_q;
  assign cause_o          = cause_q;
  assign dbg_cause_o      = dbg_cause_q;
  assign fault_addr_o     = fault_q;
  assign depc_o           = depc_q;

  // R1/R4/R6/R8: every taken entry leaves exception mode set
  a_r1_excm_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> ps_o[PS_EXCM_BIT]);

  // R2: a double fault records the PC in the double-fault register, not in level 1
  a_r2_double_keeps_epc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_DEPC && exc_req_i && !nmi_req_i && !dbg_req_i && !irq_req_i && ps_o[PS_EXCM_BIT])
    |=> (depc_o == $past(pc_i)) && $stable(epc_q[0]));

  // R3: the fault address only moves on an exception carrying an address
  a_r3_vaddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_req_i || !exc_vaddr_vld_i) |=> $stable(fault_addr_o));

  // R5: a debug request alone at or above the debug level causes no redirect
  a_r5_dbg_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !nmi_req_i && !irq_req_i && !exc_req_i &&
     ps_o[LVL_W-1:0] >= LVL_W'(DEBUG_LEVEL)) |=> !redirect_valid_o);

  // R8: NMI always redirects and lands at its level
  a_r8_nmi_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_i |=> redirect_valid_o && (ps_o[LVL_W-1:0] == LVL_W'(NMI_LEVEL)));

  // R12: no request, no redirect
  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_req_i && !dbg_req_i && !irq_req_i && !exc_req_i) |=> !redirect_valid_o);
endmodule

// File: tb/exc_entry_tb.sv
`timescale 1ns/1ps
module exc_entry_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        exc_req = 0, exc_vv = 0, dbg_req = 0, irq_req = 0, nmi_req = 0;
  logic [5:0]  exc_cause = '0, dbg_cause = '0;
  logic [31:0] exc_vaddr = '0;
  logic [3:0]  irq_level = '0, lvl_sel = '0;
  logic        ps_we = 0, vb_we = 0;
  logic [7:0]  ps_wdata = '0;
  logic [31:0] vb_wdata = '0;
  logic        rv;
  logic [31:0] rpc, fault, depc, epc_sel;
  logic [7:0]  ps, eps_sel;
  logic [5:0]  cause, dcause;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc),
    .exc_req_i(exc_req), .exc_cause_i(exc_cause),
    .exc_vaddr_vld_i(exc_vv), .exc_vaddr_i(exc_vaddr),
    .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause),
    .irq_req_i(irq_req), .irq_level_i(irq_level), .nmi_req_i(nmi_req),
    .ps_we_i(ps_we), .ps_wdata_i(ps_wdata),
    .vecbase_we_i(vb_we), .vecbase_wdata_i(vb_wdata), .lvl_sel_i(lvl_sel),
    .redirect_valid_o(rv), .redirect_pc_o(rpc), .ps_o(ps),
    .cause_o(cause), .dbg_cause_o(dcause), .fault_addr_o(fault),
    .depc_o(depc), .epc_sel_o(epc_sel), .eps_sel_o(eps_sel)
  );

  localparam logic [31:0] B = 32'h4000_0000;

  typedef struct packed {
    logic [7:0]  ps0;
    logic [1:0]  kind;   // 0 exc, 1 dbg, 2 irq, 3 nmi
    logic [3:0]  lvl;
    logic        vld;
    logic [11:0] off;
    logic [7:0]  ps1;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 2'd0, 4'd0, 1'b1, 12'h300, 8'h10, 4'd1},
    '{8'h20, 2'd0, 4'd0, 1'b1, 12'h340, 8'h30, 4'd1},
    '{8'h30, 2'd0, 4'd0, 1'b1, 12'h3C0, 8'h30, 4'd2},
    '{8'h00, 2'd2, 4'd1, 1'b1, 12'h300, 8'h10, 4'd7},
    '{8'h20, 2'd2, 4'd1, 1'b1, 12'h340, 8'h30, 4'd7},
    '{8'h10, 2'd2, 4'd1, 1'b0, 12'h000, 8'h10, 4'd10},
    '{8'h00, 2'd2, 4'd2, 1'b1, 12'h180, 8'h12, 4'd6},
    '{8'h02, 2'd2, 4'd2, 1'b0, 12'h000, 8'h02, 4'd6},
    '{8'h10, 2'd2, 4'd3, 1'b0, 12'h000, 8'h10, 4'd10},
    '{8'h10, 2'd2, 4'd4, 1'b1, 12'h200, 8'h14, 4'd10},
    '{8'h05, 2'd2, 4'd6, 1'b1, 12'h280, 8'h16, 4'd6},
    '{8'h00, 2'd2, 4'd7, 1'b0, 12'h000, 8'h00, 4'd6},
    '{8'h25, 2'd1, 4'd0, 1'b1, 12'h020, 8'h36, 4'd4},
    '{8'h06, 2'd1, 4'd0, 1'b0, 12'h000, 8'h06, 4'd5},
    '{8'h0F, 2'd3, 4'd0, 1'b1, 12'h2C0, 8'h17, 4'd8},
    '{8'h14, 2'd1, 4'd0, 1'b1, 12'h020, 8'h16, 4'd4}
  };

  function automatic string rtag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd4: return "R4";
      4'd5: return "R5";   4'd6: return "R6";   4'd7: return "R7";
      4'd8: return "R8";   4'd10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start just after a negedge and return just after the next one
  task automatic write_ps(input logic [7:0] v);
    ps_we = 1; ps_wdata = v;
    @(negedge clk);
    ps_we = 0;
  endtask

  task automatic fire(input logic [1:0] kind, input logic [3:0] lvl, input logic [5:0] c,
                      input logic vv, input logic [31:0] va);
    exc_req = (kind == 2'd0); dbg_req = (kind == 2'd1);
    irq_req = (kind == 2'd2); nmi_req = (kind == 2'd3);
    irq_level = lvl; exc_cause = c; dbg_cause = c; exc_vv = vv; exc_vaddr = va;
    @(negedge clk);
    exc_req = 0; dbg_req = 0; irq_req = 0; nmi_req = 0; exc_vv = 0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    chk("R14 redirect", {31'b0, rv}, 32'd0);
    chk("R14 status", {24'b0, ps}, 32'd0);
    chk("R14 cause", {26'b0, cause}, 32'd0);
    chk("R14 fault", fault, 32'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      write_ps(VECS[i].ps0);
      pc = 32'h1000 + 32'(i) * 4;
      fire(VECS[i].kind, VECS[i].lvl, 6'd9, 1'b0, 32'd0);
      chk({rtag(VECS[i].req), " vld"}, {31'b0, rv}, {31'b0, VECS[i].vld});
      if (VECS[i].vld) chk({rtag(VECS[i].req), " pc"}, rpc, B + {20'b0, VECS[i].off});
      chk({rtag(VECS[i].req), " ps"}, {24'b0, ps}, {24'b0, VECS[i].ps1});
    end

    // R12: pulse lasts one cycle
    write_ps(8'h00);
    fire(2'd0, 4'd0, 6'd3, 1'b0, 32'd0);
    chk("R12 pulse", {31'b0, rv}, 32'd1);
    idle_cycle();
    chk("R12 pulse end", {31'b0, rv}, 32'd0);

    // R1: level-1 saved PC and cause
    write_ps(8'h00);
    pc = 32'h0000_0100;
    fire(2'd0, 4'd0, 6'd7, 1'b0, 32'd0);
    lvl_sel = 4'd1; #1;
    chk("R1 epc1", epc_sel, 32'h100);
    chk("R1 cause", {26'b0, cause}, 32'd7);

    // R2: double fault
    write_ps(8'h10);
    pc = 32'h0000_0200;
    fire(2'd0, 4'd0, 6'd8, 1'b0, 32'd0);
    chk("R2 depc", depc, 32'h200);
    chk("R2 epc1 kept", epc_sel, 32'h100);
    chk("R2 cause", {26'b0, cause}, 32'd8);

    // R3: fault address load and hold
    write_ps(8'h00);
    fire(2'd0, 4'd0, 6'd5, 1'b1, 32'hDEAD_0000);
    chk("R3 load", fault, 32'hDEAD_0000);
    write_ps(8'h00);
    fire(2'd0, 4'd0, 6'd5, 1'b0, 32'h0000_0001);
    chk("R3 no flag", fault, 32'hDEAD_0000);

    // R7: level-1 interrupt cause and untouched fault address
    write_ps(8'h00);
    fire(2'd2, 4'd1, 6'd5, 1'b1, 32'h0000_0002);
    chk("R7 cause", {26'b0, cause}, 32'd4);
    chk("R7 fault kept", fault, 32'hDEAD_0000);

    // R4: debug saves
    write_ps(8'h25);
    pc = 32'h0000_1234;
    fire(2'd1, 4'd0, 6'h11, 1'b0, 32'd0);
    lvl_sel = 4'd6; #1;
    chk("R4 epc6", epc_sel, 32'h1234);
    chk("R4 eps6", {24'b0, eps_sel}, 32'h25);
    chk("R4 dbg cause", {26'b0, dcause}, 32'h11);

    // R5: blocked debug changes nothing
    write_ps(8'h07);
    pc = 32'h0000_9999;
    fire(2'd1, 4'd0, 6'h22, 1'b0, 32'd0);
    chk("R5 no redirect", {31'b0, rv}, 32'd0);
    chk("R5 dbg cause kept", {26'b0, dcause}, 32'h11);
    chk("R5 epc6 kept", epc_sel, 32'h1234);

    // R6: high interrupt saves
    write_ps(8'h01);
    pc = 32'h0000_AAA0;
    fire(2'd2, 4'd4, 6'd0, 1'b0, 32'd0);
    lvl_sel = 4'd4; #1;
    chk("R6 epc4", epc_sel, 32'hAAA0);
    chk("R6 eps4", {24'b0, eps_sel}, 32'h01);

    // R8: NMI saves
    write_ps(8'h3F);
    pc = 32'h0000_BBB0;
    fire(2'd3, 4'd0, 6'd0, 1'b0, 32'd0);
    lvl_sel = 4'd7; #1;
    chk("R8 pc", rpc, B + 32'h2C0);
    chk("R8 epc7", epc_sel, 32'hBBB0);
    chk("R8 eps7", {24'b0, eps_sel}, 32'h3F);

    // R11: all four at once -> NMI; causes untouched
    write_ps(8'h00);
    exc_req = 1; dbg_req = 1; irq_req = 1; nmi_req = 1;
    irq_level = 4'd2; exc_cause = 6'd30; dbg_cause = 6'd31;
    @(negedge clk);
    exc_req = 0; dbg_req = 0; irq_req = 0; nmi_req = 0;
    chk("R11 nmi wins", rpc, B + 32'h2C0);
    chk("R11 cause kept", {26'b0, cause}, 32'd4);
    chk("R11 dbg cause kept", {26'b0, dcause}, 32'h11);
    // debug beats interrupt and exception
    write_ps(8'h00);
    exc_req = 1; dbg_req = 1; irq_req = 1; irq_level = 4'd2;
    @(negedge clk);
    exc_req = 0; dbg_req = 0; irq_req = 0;
    chk("R11 dbg wins", rpc, B + 32'h020);
    chk("R11 dbg cause", {26'b0, dcause}, 32'd31);
    chk("R11 cause kept 2", {26'b0, cause}, 32'd4);
    // interrupt beats exception
    write_ps(8'h00);
    exc_req = 1; irq_req = 1; irq_level = 4'd3;
    @(negedge clk);
    exc_req = 0; irq_req = 0;
    chk("R11 irq wins", rpc, B + 32'h1C0);
    chk("R11 cause kept 3", {26'b0, cause}, 32'd4);
    // blocked debug does not hide exception
    write_ps(8'h06);
    exc_req = 1; dbg_req = 1; exc_cause = 6'd12;
    @(negedge clk);
    exc_req = 0; dbg_req = 0;
    chk("R11 exc after blocked dbg", rpc, B + 32'h300);
    chk("R11 exc cause", {26'b0, cause}, 32'd12);

    // R13: entry overrides status load
    write_ps(8'h20);
    ps_we = 1; ps_wdata = 8'h03; exc_req = 1;
    @(negedge clk);
    ps_we = 0; exc_req = 0;
    chk("R13 entry wins", {24'b0, ps}, 32'h30);
    write_ps(8'h03);
    chk("R13 plain load", {24'b0, ps}, 32'h03);

    // R9: relocation
    vb_we = 1; vb_wdata = 32'h8000_0000;
    @(negedge clk);
    vb_we = 0;
    write_ps(8'h00);
    fire(2'd0, 4'd0, 6'd1, 1'b0, 32'd0);
    chk("R9 kernel reloc", rpc, 32'h8000_0300);
    write_ps(8'h00);
    fire(2'd2, 4'd2, 6'd0, 1'b0, 32'd0);
    chk("R9 irq reloc", rpc, 32'h8000_0180);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule